// File: doc/BRIEF.md
# Nibble-Sliced Eight-Bit ALU with Flag Register

This block is the arithmetic and logic unit of a small eight-bit datapath. One operand is always the accumulator. The other is chosen from constant zero, the B register, or either byte of the memory pointer. A swap input reverses the two operands, so `x - y` becomes `y - x`. The eight-bit result is combinational. Four flags (zero, carry, sign and signed overflow) are captured into a flag register on each clock edge.

The datapath is split into two four-bit slices. Each slice sees only its own nibble of both operands. The two slices share exactly one link bit, and the top bit of the opcode decides which way it flows:
- Opcodes 0 to 7 send the bit from the low slice to the high slice. These are the adds, subtracts and left shift.
- Opcodes 8 to 15 send the bit from the high slice to the low slice. These are the right shifts.

Because of this, every operation must be placed in the opcode half whose link direction it needs. The stored carry feeds back into the carry-using operations. A MOV leaves the flag register untouched, so register copies do not disturb conditions that a later branch will test.

Top module: `nibble_alu`

## Requirements
- R1: `opsel_i` picks the second operand: 2'b00 is constant zero, 2'b01 is `b_i`, 2'b10 is `pl_i` and 2'b11 is `ph_i`.
- R2: When `swap_i` is 1, the accumulator `a_i` and the selected operand trade places, so the result is computed with the selected operand as `x` and `a_i` as `y`.
- R3: The arithmetic opcodes carry across the nibble boundary:
  - Opcode 0 gives `x+y`.
  - Opcode 1 gives `x-y`.
  - Carry is set on an unsigned carry-out for adds.
  - Carry is set on a borrow for subtracts.
- R4: Opcode 2 gives `x+y+C` and opcode 3 gives `x-y-C`, where C is the stored carry flag.
- R5: The logic opcodes clear both carry and overflow. They are: 4 AND, 5 OR, 6 XOR, 11 NOT x, 13 XNOR, 14 `x & ~y` and 15 NOR.
- R6: The shift opcodes behave as follows:
  - 7 shifts left by one, filling with 0; carry gets old bit 7.
  - 8 shifts right logically; carry gets old bit 0.
  - 9 rotates right through the stored carry; carry gets old bit 0.
  - 12 shifts right arithmetically; carry gets old bit 0.
- R7: For any opcode other than MOV, the flag register loads on the next rising clock edge: zero is 1 exactly when the result is 0, and sign equals result bit 7.
- R8: The overflow flag is computed from the x and y signs and the result sign; for every opcode other than 0 to 3 it is 0.
  - For opcodes 0 and 2, overflow is 1 when x and y have the same sign and the result sign differs from x.
  - For opcodes 1 and 3, overflow is 1 when x and y have different signs and the result sign differs from x.
- R9: Opcode 10 (MOV) outputs `y` unchanged and leaves all four flags as they were.
- R10: An active-low `rst_n` clears all four flags asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 4 | Operation code |
| opsel_i | input | 2 | Second operand select |
| swap_i | input | 1 | Operand swap |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | B register value |
| pl_i | input | 8 | Low byte of the pointer |
| ph_i | input | 8 | High byte of the pointer |
| res_o | output | 8 | Combinational result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry/borrow flag |
| sign_o | output | 1 | Registered sign flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The assertions check several relations on every cycle:
- The zero and sign flags follow the previous cycle's result.
- MOV holds all flags steady.
- Logic operations clear carry and overflow.
- The left shift moves the old top bit into carry.
- Operand select zero yields a zero MOV result.

The exact values that cross the slice boundary can only be shown by the bench's vectors. These cover:
- nibble carries and borrows;
- bit 4 moving down on right shifts;
- rotation through the stored carry;
- the signed overflow corners;
- the effect of the swap bit.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_RORC = 4'd9,
        OP_MOV  = 4'd10,
        OP_NOT  = 4'd11,
        OP_ASR  = 4'd12,
        OP_XNOR = 4'd13,
        OP_ANDN = 4'd14,
        OP_NOR  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic sign;
        logic ovf;
    } alu_flags_t;

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic         swap_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] pl_i,
    input  logic [W-1:0] ph_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);

    logic [W-1:0] other;

    always_comb begin
        unique case (sel_i)
            2'b00:   other = '0;
            2'b01:   other = b_i;
            2'b10:   other = pl_i;
            default: other = ph_i;
        endcase
        x_o = swap_i ? other : acc_i;
        y_o = swap_i ? acc_i : other;
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
#(
    parameter int SW    = 4,
    parameter bit UPPER = 1'b0
) (
    input  logic [SW-1:0] x_i,
    input  logic [SW-1:0] y_i,
    input  alu_op_e       op_i,
    input  logic          cst_i,
    input  logic          link_i,
    output logic [SW-1:0] r_o,
    output logic          c_o,
    output logic          v_o,
    output logic          link_o
);

    logic          lo_cin;
    logic [SW:0]   lo_sum;
    logic [SW:0]   lo_dif;
    logic          cin;
    logic [SW:0]   sum;
    logic [SW:0]   dif;
    logic          fill;

    // carry chain seen by the lower slice only: no dependence on link_i
    always_comb begin
        lo_cin = (op_i == OP_ADC || op_i == OP_SBC) ? cst_i : 1'b0;
        lo_sum = {1'b0, x_i} + {1'b0, y_i} + {{SW{1'b0}}, lo_cin};
        lo_dif = {1'b0, x_i} - {1'b0, y_i} - {{SW{1'b0}}, lo_cin};
    end

    always_comb begin
        link_o = 1'b0;
        if (!UPPER) begin
            unique case (op_i)
                OP_ADD, OP_ADC: link_o = lo_sum[SW];
                OP_SUB, OP_SBC: link_o = lo_dif[SW];
                OP_SHL:         link_o = x_i[SW-1];
                default:        link_o = 1'b0;
            endcase
        end else begin
            unique case (op_i)
                OP_SHR, OP_RORC, OP_ASR: link_o = x_i[0];
                default:                 link_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        cin = UPPER ? link_i : lo_cin;
        sum = {1'b0, x_i} + {1'b0, y_i} + {{SW{1'b0}}, cin};
        dif = {1'b0, x_i} - {1'b0, y_i} - {{SW{1'b0}}, cin};
        c_o = 1'b0;
        v_o = 1'b0;
        fill = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC: r_o = sum[SW-1:0];
            OP_SUB, OP_SBC: r_o = dif[SW-1:0];
            OP_AND:  r_o = x_i & y_i;
            OP_OR:   r_o = x_i | y_i;
            OP_XOR:  r_o = x_i ^ y_i;
            OP_SHL:  r_o = {x_i[SW-2:0], (UPPER ? link_i : 1'b0)};
            OP_SHR: begin
                fill = UPPER ? 1'b0 : link_i;
                r_o  = {fill, x_i[SW-1:1]};
            end
            OP_RORC: begin
                fill = UPPER ? cst_i : link_i;
                r_o  = {fill, x_i[SW-1:1]};
            end
            OP_ASR: begin
                fill = UPPER ? x_i[SW-1] : link_i;
                r_o  = {fill, x_i[SW-1:1]};
            end
            OP_MOV:  r_o = y_i;
            OP_NOT:  r_o = ~x_i;
            OP_XNOR: r_o = ~(x_i ^ y_i);
            OP_ANDN: r_o = x_i & ~y_i;
            default: r_o = ~(x_i | y_i);
        endcase
        if (UPPER) begin
            unique case (op_i)
                OP_ADD, OP_ADC: begin
                    c_o = sum[SW];
                    v_o = (x_i[SW-1] == y_i[SW-1]) && (r_o[SW-1] != x_i[SW-1]);
                end
                OP_SUB, OP_SBC: begin
                    c_o = dif[SW];
                    v_o = (x_i[SW-1] != y_i[SW-1]) && (r_o[SW-1] != x_i[SW-1]);
                end
                OP_SHL:  c_o = x_i[SW-1];
                default: c_o = 1'b0;
            endcase
        end else begin
            unique case (op_i)
                OP_SHR, OP_RORC, OP_ASR: c_o = x_i[0];
                default:                 c_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [1:0]   opsel_i,
    input  logic         swap_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] pl_i,
    input  logic [W-1:0] ph_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         carry_o,
    output logic         sign_o,
    output logic         ovf_o
);

    localparam int NSL = 2;
    localparam int SW  = W / NSL;

    alu_op_e      op;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [NSL-1:0] c_sl;
    logic [NSL-1:0] v_sl;
    logic [NSL-1:0] lnk_out;
    logic [NSL-1:0] lnk_in;
    alu_flags_t   flags_d;
    alu_flags_t   flags_q;

    assign op = alu_op_e'(op_i);

    alu_opnd_sel #(.W(W)) u_sel (
        .sel_i  (opsel_i),
        .swap_i (swap_i),
        .acc_i  (a_i),
        .b_i    (b_i),
        .pl_i   (pl_i),
        .ph_i   (ph_i),
        .x_o    (x),
        .y_o    (y)
    );

    // op bit 3 gates the single link: upward for 0..7, downward for 8..15
    assign lnk_in[0] = op_i[3] ? lnk_out[1] : 1'b0;
    assign lnk_in[1] = op_i[3] ? 1'b0 : lnk_out[0];

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        alu_slice #(.SW(SW), .UPPER(g == NSL - 1)) u_slice (
            .x_i    (x[g*SW +: SW]),
            .y_i    (y[g*SW +: SW]),
            .op_i   (op),
            .cst_i  (flags_q.carry),
            .link_i (lnk_in[g]),
            .r_o    (res_o[g*SW +: SW]),
            .c_o    (c_sl[g]),
            .v_o    (v_sl[g]),
            .link_o (lnk_out[g])
        );
    end

    always_comb begin
        flags_d = flags_q;
        if (op != OP_MOV) begin
            flags_d.zero  = ~|res_o;
            flags_d.carry = |c_sl;
            flags_d.sign  = res_o[W-1];
            flags_d.ovf   = v_sl[NSL-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign zero_o  = flags_q.zero;
    assign carry_o = flags_q.carry;
    assign sign_o  = flags_q.sign;
    assign ovf_o   = flags_q.ovf;

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [1:0]   opsel_i,
    input logic         swap_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] res_o,
    input logic         zero_o,
    input logic         carry_o,
    input logic         sign_o,
    input logic         ovf_o
);

    localparam logic [3:0] MOV = 4'd10;

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != MOV) |=> (zero_o == ($past(res_o) == '0)));

    p_sign_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != MOV) |=> (sign_o == $past(res_o[W-1])));

    p_mov_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == MOV) |=> ($stable(zero_o) && $stable(carry_o) && $stable(sign_o) && $stable(ovf_o)));

    p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6 || op_i == 4'd11 ||
         op_i == 4'd13 || op_i == 4'd14 || op_i == 4'd15) |=> (!carry_o && !ovf_o));

    p_shl_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7 && !swap_i) |=> (carry_o == $past(a_i[W-1])));

    p_sel_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == MOV && opsel_i == 2'b00 && !swap_i) |-> (res_o == '0));

    p_no_ovf_nonarith_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd4 && op_i != MOV) |=> !ovf_o);

endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .opsel_i (opsel_i),
    .swap_i  (swap_i),
    .a_i     (a_i),
    .res_o   (res_o),
    .zero_o  (zero_o),
    .carry_o (carry_o),
    .sign_o  (sign_o),
    .ovf_o   (ovf_o)
);

// File: tb/nibble_alu_tb.sv
module nibble_alu_tb;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] y;
        logic [1:0] sel;
        logic [3:0] op;
        logic       swp;
        logic       cin;
        logic [7:0] res;
        logic [3:0] fl;   // {zero, carry, sign, ovf}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam logic [7:0] PL_V = 8'h5A;
    localparam logic [7:0] PH_V = 8'hC3;

    localparam vec_t VECS [NV] = '{
        '{8'h3A, 8'h28, 2'd1, 4'd0,  1'b0, 1'b0, 8'h62, 4'b0000, 4'd3}, // R3 nibble carry
        '{8'h7F, 8'h01, 2'd1, 4'd0,  1'b0, 1'b0, 8'h80, 4'b0011, 4'd8}, // R8 add overflow
        '{8'hFF, 8'h01, 2'd1, 4'd0,  1'b0, 1'b0, 8'h00, 4'b1100, 4'd3}, // R3 carry out
        '{8'h10, 8'h01, 2'd1, 4'd1,  1'b0, 1'b0, 8'h0F, 4'b0000, 4'd3}, // R3 nibble borrow
        '{8'h01, 8'h02, 2'd1, 4'd1,  1'b0, 1'b0, 8'hFF, 4'b0110, 4'd3}, // R3 borrow out
        '{8'h80, 8'h01, 2'd1, 4'd1,  1'b0, 1'b0, 8'h7F, 4'b0001, 4'd8}, // R8 sub overflow
        '{8'h05, 8'h03, 2'd1, 4'd1,  1'b1, 1'b0, 8'hFE, 4'b0110, 4'd2}, // R2 swapped sub
        '{8'h0F, 8'h00, 2'd1, 4'd2,  1'b0, 1'b1, 8'h10, 4'b0000, 4'd4}, // R4 adc c=1
        '{8'h0F, 8'h00, 2'd1, 4'd2,  1'b0, 1'b0, 8'h0F, 4'b0000, 4'd4}, // R4 adc c=0
        '{8'h10, 8'h00, 2'd1, 4'd3,  1'b0, 1'b1, 8'h0F, 4'b0000, 4'd4}, // R4 sbc c=1
        '{8'hF0, 8'h3C, 2'd1, 4'd4,  1'b0, 1'b1, 8'h30, 4'b0000, 4'd5}, // R5 and
        '{8'h0F, 8'h30, 2'd1, 4'd5,  1'b0, 1'b1, 8'h3F, 4'b0000, 4'd5}, // R5 or
        '{8'hFF, 8'hFF, 2'd1, 4'd6,  1'b0, 1'b0, 8'h00, 4'b1000, 4'd5}, // R5 xor
        '{8'h88, 8'h00, 2'd1, 4'd7,  1'b0, 1'b0, 8'h10, 4'b0100, 4'd6}, // R6 shl
        '{8'h11, 8'h00, 2'd1, 4'd8,  1'b0, 1'b0, 8'h08, 4'b0100, 4'd6}, // R6 shr
        '{8'h10, 8'h00, 2'd1, 4'd9,  1'b0, 1'b1, 8'h88, 4'b0010, 4'd6}, // R6 ror c=1
        '{8'h01, 8'h00, 2'd1, 4'd9,  1'b0, 1'b0, 8'h00, 4'b1100, 4'd6}, // R6 ror c=0
        '{8'h90, 8'h00, 2'd1, 4'd12, 1'b0, 1'b0, 8'hC8, 4'b0010, 4'd6}, // R6 asr
        '{8'h12, 8'h77, 2'd1, 4'd10, 1'b0, 1'b1, 8'h77, 4'b1100, 4'd9}, // R9 mov holds
        '{8'h12, 8'h77, 2'd1, 4'd10, 1'b1, 1'b0, 8'h12, 4'b1000, 4'd2}, // R2 swapped mov
        '{8'h12, 8'h77, 2'd0, 4'd10, 1'b0, 1'b0, 8'h00, 4'b1000, 4'd1}, // R1 sel zero
        '{8'h12, 8'h77, 2'd2, 4'd10, 1'b0, 1'b0, PL_V,  4'b1000, 4'd1}, // R1 sel pl
        '{8'h12, 8'h77, 2'd3, 4'd10, 1'b0, 1'b1, PH_V,  4'b1100, 4'd1}, // R1 sel ph
        '{8'h0F, 8'h00, 2'd1, 4'd11, 1'b0, 1'b1, 8'hF0, 4'b0010, 4'd5}, // R5 not
        '{8'h0F, 8'h0F, 2'd1, 4'd13, 1'b0, 1'b0, 8'hFF, 4'b0010, 4'd5}, // R5 xnor
        '{8'hFF, 8'h0F, 2'd1, 4'd14, 1'b0, 1'b1, 8'hF0, 4'b0010, 4'd5}, // R5 andn
        '{8'h00, 8'h00, 2'd0, 4'd15, 1'b0, 1'b0, 8'hFF, 4'b0010, 4'd7}  // R7 nor sign
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd10;
    logic [1:0] opsel_i = 2'd0;
    logic       swap_i = 1'b0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [7:0] pl_i = PL_V;
    logic [7:0] ph_i = PH_V;
    logic [7:0] res_o;
    logic       zero_o, carry_o, sign_o, ovf_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nibble_alu u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .opsel_i (opsel_i),
        .swap_i  (swap_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .pl_i    (pl_i),
        .ph_i    (ph_i),
        .res_o   (res_o),
        .zero_o  (zero_o),
        .carry_o (carry_o),
        .sign_o  (sign_o),
        .ovf_o   (ovf_o)
    );

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // preset the stored carry: SHR of 0x01 sets it, AND with zero clears it
    task automatic preset_carry(input logic c);
        @(negedge clk);
        a_i = 8'h01; opsel_i = 2'd0; swap_i = 1'b0;
        op_i = c ? 4'd8 : 4'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 flags in reset", {4'b0, zero_o, carry_o, sign_o, ovf_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 mov after reset keeps cleared flags", {4'b0, zero_o, carry_o, sign_o, ovf_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            preset_carry(VECS[i].cin);
            @(negedge clk);
            a_i = VECS[i].a; b_i = VECS[i].y; opsel_i = VECS[i].sel;
            op_i = VECS[i].op; swap_i = VECS[i].swp;
            #1;
            check($sformatf("R%0d result vec %0d", VECS[i].req, i), res_o, VECS[i].res);
            @(negedge clk);
            check($sformatf("R%0d flags vec %0d", VECS[i].req, i),
                  {4'b0, zero_o, carry_o, sign_o, ovf_o}, {4'b0, VECS[i].fl});
        end

        // R10: reset mid-run clears flags set by an add with carry-out
        @(negedge clk);
        a_i = 8'hFF; b_i = 8'h01; opsel_i = 2'd1; swap_i = 1'b0; op_i = 4'd0;
        @(negedge clk);
        check("R7 flags before reset", {4'b0, zero_o, carry_o, sign_o, ovf_o}, 8'h0C);
        op_i = 4'd10;
        rst_n = 1'b0;
        #1;
        check("R10 async clear", {4'b0, zero_o, carry_o, sign_o, ovf_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule